// File: doc/BRIEF.md
# Passive Truth-Table Vector Checker

This block watches the pins of one small combinational IC while the board around it runs normally. It never drives the chip. An external comparator front end reduces every pin to a 2-bit level code. The block samples those codes on a chosen edge of a trigger signal from the circuit under test. It accepts a sample only after the pin levels have stayed steady for a programmable number of trigger edges, and only while the checking window is open. Each accepted sample is checked against a loadable truth table that holds one expected output word for every input combination.

Pins are assigned roles: input, output, ground or supply. Input-role pins are packed in ascending pin order to form the table index. Output-role pins are packed the same way to form the observed word. The block records which combinations were seen and which failed, and counts the distinct combinations exercised. It latches the first mismatch and flags rail pins that read the wrong level. A four-way verdict tells a good chip apart from a failing one, from one the circuit exercised only partly, and from one that could not be judged because an input sat at an invalid level.

Top module: `truth_vector_checker`

## Requirements
- R1: A sample event occurs only on the selected trigger transition: a 0 to 1 change of `trig_clk` when `trig_rise`=1, or a 1 to 0 change when `trig_rise`=0. The result of an event is visible on the outputs one `clk` cycle after the cycle in which the transition is seen.
- R2: On each event the settle count becomes one more than before (saturating at its maximum) if all pin level codes equal those of the previous event, and 0 otherwise. The sample is accepted only when that new count is at least `settle_n`.
- R3: Samples are recorded only while `start`=1 and `stop`=0. Outside that window, coverage, failure state and rail state do not change.
- R4: Level codes are 00 = valid low, 01 = valid high, 1x = invalid. Pin role codes are 00 = input, 01 = output, 10 = ground, 11 = supply, with pin p in bits [2p+1:2p]. The k-th input-role pin in ascending pin order is bit k of the table index, and the k-th output-role pin is bit k of the observed word.
- R5: An accepted sample in which a ground pin is not 00, or a supply pin is not 01, sets `rail_fault`. The flag stays set until a clear.
- R6: `cov_count` equals the number of distinct valid input combinations accepted, and `combo_seen[i]` is 1 exactly for those combinations.
- R7: An accepted valid-input sample fails if any output pin is invalid or the observed word differs from the table entry. Unused expected bits must be 0. A failure sets `combo_fail[index]`. The first failure latches `ff_in`, `ff_obs` and `ff_exp` and sets `ff_valid`, and these hold through later failures.
- R8: `verdict` is 1 (failure) if any combination failed or `rail_fault` is set. Otherwise it is 3 (not testable) if an accepted sample had an invalid input. Otherwise it is 2 (incomplete) if `cov_count` is below 2^(number of input-role pins). Otherwise it is 0 (all good).
- R9: A table write (`tbl_we`) takes effect only while the window is closed. A write made while the window is open is ignored.
- R10: A synchronous `clr` empties both combination maps and the coverage count, drops `ff_valid`, `rail_fault` and the invalid-input flag, and restarts the settle filter.
- R11: After reset, `verdict`=2, `cov_count`=0, and `ff_valid`=0 and `rail_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of results |
| trig_clk | input | 1 | Trigger signal from the circuit under test |
| trig_rise | input | 1 | 1: sample on rising trigger, 0: on falling |
| start | input | 1 | Window open condition (high) |
| stop | input | 1 | Window close condition (high) |
| settle_n | input | SW | Required count of identical prior samples |
| pin_role | input | 2*NPIN | Role code per pin |
| pin_lvl | input | 2*NPIN | Level code per pin from the front end |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | IN_W | Table write address (input combination) |
| tbl_data | input | OUT_W | Expected output word |
| verdict | output | 2 | Chip verdict code |
| cov_count | output | IN_W+1 | Distinct combinations exercised |
| combo_seen | output | 2^IN_W | Per-combination seen map |
| combo_fail | output | 2^IN_W | Per-combination failed map |
| rail_fault | output | 1 | Ground or supply pin misread |
| ff_valid | output | 1 | First-failure record is valid |
| ff_in | output | IN_W | Input word of first failure |
| ff_obs | output | OUT_W | Observed output of first failure |
| ff_exp | output | OUT_W | Expected output of first failure |

## Verification
The block is set up as a quad 2-input NAND. A full sweep of all 256 input words with correct outputs must end in the all-good verdict; this tells a complete, correct run apart from a partial one and shows that a write made inside the window was ignored. Single faults follow, one per run: a wrong output bit, an output at an invalid level, an input at an invalid level, and a ground pin reading high. Each must reach its own verdict and first-failure contents, so the four verdict codes and their priority can be told apart. Trigger changes of the wrong polarity, samples taken with the window closed, and pin levels that change between edges under a nonzero settle count must all leave the record unchanged. These cases separate the edge qualifier, the window and the filter from the checking path.

// File: rtl/tvc_pkg.sv
package tvc_pkg;
   localparam logic [1:0] LV_LOW    = 2'b00;
   localparam logic [1:0] LV_HIGH   = 2'b01;
   localparam logic [1:0] ROLE_IN   = 2'b00;
   localparam logic [1:0] ROLE_OUT  = 2'b01;
   localparam logic [1:0] ROLE_GND  = 2'b10;
   localparam logic [1:0] ROLE_VCC  = 2'b11;

   typedef enum logic [1:0] {
      VD_GOOD       = 2'd0,
      VD_FAIL       = 2'd1,
      VD_PARTIAL    = 2'd2,
      VD_UNTESTABLE = 2'd3
   } verdict_t;
endpackage

// File: rtl/tvc_pin_router.sv
// Packs role-tagged pins into an input index and an observed output word,
// and reports invalid levels per role group.
module tvc_pin_router
   import tvc_pkg::*;
#(
   parameter int NPIN  = 16,
   parameter int IN_W  = 8,
   parameter int OUT_W = 8,
   localparam int NW   = $clog2(NPIN + 1),
   localparam int IB   = $clog2(IN_W),
   localparam int OB   = $clog2(OUT_W)
) (
   input  logic [2*NPIN-1:0] pin_role,
   input  logic [2*NPIN-1:0] pin_lvl,
   output logic [IN_W-1:0]   in_word,
   output logic [OUT_W-1:0]  out_word,
   output logic              in_bad,
   output logic              out_bad,
   output logic              rail_bad,
   output logic [NW-1:0]     n_in
);
   always_comb begin
      logic [NW-1:0] ki;
      logic [NW-1:0] ko;
      logic [1:0]    rl;
      logic [1:0]    lv;
      in_word  = '0;
      out_word = '0;
      in_bad   = 1'b0;
      out_bad  = 1'b0;
      rail_bad = 1'b0;
      ki       = '0;
      ko       = '0;
      for (int p = 0; p < NPIN; p++) begin
         rl = pin_role[2*p +: 2];
         lv = pin_lvl[2*p +: 2];
         case (rl)
            ROLE_IN: begin
               if (ki < NW'(IN_W)) begin
                  in_word[ki[IB-1:0]] = (lv == LV_HIGH);
                  in_bad = in_bad | lv[1];
                  ki = ki + 1'b1;
               end
            end
            ROLE_OUT: begin
               if (ko < NW'(OUT_W)) begin
                  out_word[ko[OB-1:0]] = (lv == LV_HIGH);
                  out_bad = out_bad | lv[1];
                  ko = ko + 1'b1;
               end
            end
            ROLE_GND: rail_bad = rail_bad | (lv != LV_LOW);
            default:  rail_bad = rail_bad | (lv != LV_HIGH);
         endcase
      end
      n_in = ki;
   end
endmodule

// File: rtl/tvc_settle.sv
// Counts consecutive identical samples and qualifies acceptance.
module tvc_settle #(
   parameter int W  = 32,
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          evt,
   input  logic [W-1:0]  lvl,
   input  logic [SW-1:0] settle_n,
   output logic          accept
);
   localparam logic [SW-1:0] CMAX = '1;

   logic [W-1:0]  prev_q;
   logic          have_q;
   logic [SW-1:0] cnt_q;
   logic [SW-1:0] cnt_nx;

   always_comb begin
      if (have_q && (lvl == prev_q))
         cnt_nx = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
      else
         cnt_nx = '0;
   end

   assign accept = evt && (cnt_nx >= settle_n);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         prev_q <= '0;
         have_q <= 1'b0;
         cnt_q  <= '0;
      end else if (evt) begin
         prev_q <= lvl;
         have_q <= 1'b1;
         cnt_q  <= cnt_nx;
      end
   end
endmodule

// File: rtl/tvc_cov_track.sv
// Per-combination seen/failed maps, coverage counter, first-failure record.
module tvc_cov_track #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 8,
   localparam int DEPTH = 1 << IN_W,
   localparam int CW    = IN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             acc,
   input  logic [IN_W-1:0]  in_word,
   input  logic [OUT_W-1:0] obs,
   input  logic [OUT_W-1:0] expv,
   input  logic             in_bad,
   input  logic             out_bad,
   input  logic             rail_bad,
   output logic [CW-1:0]    cov_count,
   output logic [DEPTH-1:0] seen_map,
   output logic [DEPTH-1:0] fail_map,
   output logic             in_bad_seen,
   output logic             rail_fault,
   output logic             ff_valid,
   output logic [IN_W-1:0]  ff_in,
   output logic [OUT_W-1:0] ff_obs,
   output logic [OUT_W-1:0] ff_exp
);
   logic chk_ok;
   logic mis;

   assign chk_ok = acc && !in_bad;
   assign mis    = out_bad || (obs != expv);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cov_count   <= '0;
         seen_map    <= '0;
         fail_map    <= '0;
         in_bad_seen <= 1'b0;
         rail_fault  <= 1'b0;
         ff_valid    <= 1'b0;
         ff_in       <= '0;
         ff_obs      <= '0;
         ff_exp      <= '0;
      end else begin
         if (acc && rail_bad) rail_fault  <= 1'b1;
         if (acc && in_bad)   in_bad_seen <= 1'b1;
         if (chk_ok) begin
            seen_map[in_word] <= 1'b1;
            if (!seen_map[in_word]) cov_count <= cov_count + 1'b1;
            if (mis) begin
               fail_map[in_word] <= 1'b1;
               if (!ff_valid) begin
                  ff_valid <= 1'b1;
                  ff_in    <= in_word;
                  ff_obs   <= obs;
                  ff_exp   <= expv;
               end
            end
         end
      end
   end
endmodule

// File: rtl/truth_vector_checker.sv
module truth_vector_checker
   import tvc_pkg::*;
#(
   parameter int NPIN  = 16,
   parameter int IN_W  = 8,
   parameter int OUT_W = 8,
   parameter int SW    = 4,
   localparam int DEPTH = 1 << IN_W,
   localparam int CW    = IN_W + 1,
   localparam int NW    = $clog2(NPIN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              trig_clk,
   input  logic              trig_rise,
   input  logic              start,
   input  logic              stop,
   input  logic [SW-1:0]     settle_n,
   input  logic [2*NPIN-1:0] pin_role,
   input  logic [2*NPIN-1:0] pin_lvl,
   input  logic              tbl_we,
   input  logic [IN_W-1:0]   tbl_addr,
   input  logic [OUT_W-1:0]  tbl_data,
   output logic [1:0]        verdict,
   output logic [CW-1:0]     cov_count,
   output logic [DEPTH-1:0]  combo_seen,
   output logic [DEPTH-1:0]  combo_fail,
   output logic              rail_fault,
   output logic              ff_valid,
   output logic [IN_W-1:0]   ff_in,
   output logic [OUT_W-1:0]  ff_obs,
   output logic [OUT_W-1:0]  ff_exp
);
   if (IN_W < 2 || IN_W > 12) begin : g_bad_in_w
      $error("truth_vector_checker: IN_W must be 2..12");
   end
   if (OUT_W < 2 || OUT_W > 32) begin : g_bad_out_w
      $error("truth_vector_checker: OUT_W must be 2..32");
   end
   if (NPIN < 3 || SW < 1) begin : g_bad_pins
      $error("truth_vector_checker: NPIN >= 3 and SW >= 1 required");
   end

   logic              trig_q;
   logic              evt;
   logic              window;
   logic              accept;
   logic              acc;
   logic [IN_W-1:0]   in_word;
   logic [OUT_W-1:0]  out_word;
   logic              in_bad, out_bad, rail_bad, in_bad_seen;
   logic [NW-1:0]     n_in;
   logic [OUT_W-1:0]  expv;
   logic [OUT_W-1:0]  tbl_mem [DEPTH];
   logic [CW-1:0]     full_cnt;

   always_ff @(posedge clk) trig_q <= trig_clk;

   assign evt    = trig_rise ? (trig_clk & ~trig_q) : (~trig_clk & trig_q);
   assign window = start & ~stop;
   assign acc    = accept & window;

   always_ff @(posedge clk) begin
      if (tbl_we && !window) tbl_mem[tbl_addr] <= tbl_data;
   end
   assign expv = tbl_mem[in_word];

   tvc_pin_router #(.NPIN(NPIN), .IN_W(IN_W), .OUT_W(OUT_W)) u_route (
      .pin_role (pin_role),
      .pin_lvl  (pin_lvl),
      .in_word  (in_word),
      .out_word (out_word),
      .in_bad   (in_bad),
      .out_bad  (out_bad),
      .rail_bad (rail_bad),
      .n_in     (n_in)
   );

   tvc_settle #(.W(2*NPIN), .SW(SW)) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .evt      (evt),
      .lvl      (pin_lvl),
      .settle_n (settle_n),
      .accept   (accept)
   );

   tvc_cov_track #(.IN_W(IN_W), .OUT_W(OUT_W)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .acc         (acc),
      .in_word     (in_word),
      .obs         (out_word),
      .expv        (expv),
      .in_bad      (in_bad),
      .out_bad     (out_bad),
      .rail_bad    (rail_bad),
      .cov_count   (cov_count),
      .seen_map    (combo_seen),
      .fail_map    (combo_fail),
      .in_bad_seen (in_bad_seen),
      .rail_fault  (rail_fault),
      .ff_valid    (ff_valid),
      .ff_in       (ff_in),
      .ff_obs      (ff_obs),
      .ff_exp      (ff_exp)
   );

   assign full_cnt = CW'(1) << n_in;

   always_comb begin
      verdict_t v;
      if ((|combo_fail) || rail_fault) v = VD_FAIL;
      else if (in_bad_seen)            v = VD_UNTESTABLE;
      else if (cov_count < full_cnt)   v = VD_PARTIAL;
      else                             v = VD_GOOD;
      verdict = v;
   end
endmodule

// File: rtl/tvc_check.sv
module tvc_check #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 8,
   localparam int CW   = IN_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             trig_clk,
   input logic             start,
   input logic             stop,
   input logic [1:0]       verdict,
   input logic [CW-1:0]    cov_count,
   input logic             rail_fault,
   input logic             ff_valid,
   input logic [IN_W-1:0]  ff_in,
   input logic [OUT_W-1:0] ff_obs,
   input logic [OUT_W-1:0] ff_exp
);
   AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && $stable(trig_clk)) |=> ($stable(cov_count) && $stable(ff_valid))); // R1

   AST_WINDOW_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(start && !stop)) |=> ($stable(cov_count) && $stable(rail_fault))); // R3

   AST_RAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_fault && !clr) |=> rail_fault); // R5

   AST_COV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((cov_count == $past(cov_count)) ||
                (cov_count == CW'($past(cov_count) + 1'b1)))); // R6

   AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (ff_valid && !clr) |=> (ff_valid && $stable(ff_in) && $stable(ff_obs) && $stable(ff_exp))); // R7

   AST_FAIL_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      (ff_valid || rail_fault) |-> (verdict == 2'd1)); // R8

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cov_count == '0 && !ff_valid && !rail_fault)); // R10
endmodule

bind truth_vector_checker tvc_check #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr),
   .trig_clk   (trig_clk),
   .start      (start),
   .stop       (stop),
   .verdict    (verdict),
   .cov_count  (cov_count),
   .rail_fault (rail_fault),
   .ff_valid   (ff_valid),
   .ff_in      (ff_in),
   .ff_obs     (ff_obs),
   .ff_exp     (ff_exp)
);

// File: tb/sim_truth_vector_checker.sv
`timescale 1ns/1ps
module sim_truth_vector_checker;
   localparam int NPIN = 16, IN_W = 8, OUT_W = 8, SW = 4;
   localparam int DEPTH = 256, CW = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0, clr = 1'b0, trig_clk = 1'b0, trig_rise = 1'b1;
   logic start = 1'b0, stop = 1'b0, tbl_we = 1'b0;
   logic [SW-1:0] settle_n = '0;
   logic [2*NPIN-1:0] pin_role, pin_lvl;
   logic [IN_W-1:0] tbl_addr = '0;
   logic [OUT_W-1:0] tbl_data = '0;
   logic [1:0] verdict;
   logic [CW-1:0] cov_count;
   logic [DEPTH-1:0] combo_seen, combo_fail;
   logic rail_fault, ff_valid;
   logic [IN_W-1:0] ff_in;
   logic [OUT_W-1:0] ff_obs, ff_exp;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   truth_vector_checker #(.NPIN(NPIN), .IN_W(IN_W), .OUT_W(OUT_W), .SW(SW)) u0 (.*);

   // ---------------- behavioural reference model ----------------
   logic       m_tprev;
   int         m_cnt;
   logic [31:0] m_prev;
   bit         m_have;
   bit         m_seen [DEPTH];
   bit         m_fail [DEPTH];
   int         m_cov;
   bit         m_rail, m_inbad, m_ffv;
   logic [7:0] m_ffin, m_ffobs, m_ffexp;
   logic [7:0] m_tbl [DEPTH];

   task automatic m_clear();
      for (int i = 0; i < DEPTH; i++) begin m_seen[i] = 0; m_fail[i] = 0; end
      m_cov = 0; m_rail = 0; m_inbad = 0; m_ffv = 0;
      m_ffin = 0; m_ffobs = 0; m_ffexp = 0; m_cnt = 0; m_prev = 0; m_have = 0;
   endtask

   task automatic m_process();
      int ki, ko;
      logic [7:0] iv, ov;
      bit ib, ob, rb, mis;
      ki = 0; ko = 0; iv = 0; ov = 0; ib = 0; ob = 0; rb = 0;
      for (int p = 0; p < NPIN; p++) begin
         logic [1:0] r, l;
         r = pin_role[2*p +: 2]; l = pin_lvl[2*p +: 2];
         if (r == 2'b00 && ki < IN_W) begin iv[ki] = (l == 2'b01); if (l[1]) ib = 1; ki++; end
         else if (r == 2'b01 && ko < OUT_W) begin ov[ko] = (l == 2'b01); if (l[1]) ob = 1; ko++; end
         else if (r == 2'b10 && l != 2'b00) rb = 1;
         else if (r == 2'b11 && l != 2'b01) rb = 1;
      end
      if (rb) m_rail = 1;
      if (ib) m_inbad = 1;
      else begin
         if (!m_seen[iv]) m_cov++;
         m_seen[iv] = 1;
         mis = ob || (ov != m_tbl[iv]);
         if (mis) begin
            m_fail[iv] = 1;
            if (!m_ffv) begin m_ffv = 1; m_ffin = iv; m_ffobs = ov; m_ffexp = m_tbl[iv]; end
         end
      end
   endtask

   always @(posedge clk) begin
      bit evt;
      if (!rst_n) begin
         m_clear();
      end else begin
         evt = trig_rise ? (trig_clk && !m_tprev) : (!trig_clk && m_tprev);
         if (tbl_we && !(start && !stop)) m_tbl[tbl_addr] = tbl_data;
         if (clr) m_clear();
         else if (evt) begin
            if (m_have && pin_lvl == m_prev) m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
            else m_cnt = 0;
            m_prev = pin_lvl; m_have = 1;
            if (m_cnt >= int'(settle_n) && start && !stop) m_process();
         end
      end
      m_tprev = trig_clk;
   end

   function automatic int m_verdict();
      int nin, anyf;
      nin = 0; anyf = 0;
      for (int p = 0; p < NPIN; p++) if (pin_role[2*p +: 2] == 2'b00 && nin < IN_W) nin++;
      for (int i = 0; i < DEPTH; i++) if (m_fail[i]) anyf = 1;
      if (anyf || m_rail) return 1;
      if (m_inbad) return 3;
      if (m_cov < (1 << nin)) return 2;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   // per-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit mapok;
         mapok = 1;
         for (int i = 0; i < DEPTH; i++)
            if (combo_seen[i] !== m_seen[i] || combo_fail[i] !== m_fail[i]) mapok = 0;
         chk(verdict === 2'(m_verdict()), "R8 verdict", verdict, m_verdict());
         chk(cov_count === CW'(m_cov), "R6 cov_count", cov_count, m_cov);
         chk(mapok, "R6/R7 combo maps", mapok, 1);
         chk(rail_fault === m_rail, "R5 rail_fault", rail_fault, m_rail);
         chk(ff_valid === m_ffv, "R7 ff_valid", ff_valid, m_ffv);
         chk({ff_in, ff_obs, ff_exp} === {m_ffin, m_ffobs, m_ffexp}, "R7 first-failure record",
             {ff_in, ff_obs, ff_exp}, {m_ffin, m_ffobs, m_ffexp});
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [31:0] lvl_of(input logic [7:0] iv, input logic [3:0] ov);
      logic [31:0] l;
      l = '0;
      for (int i = 0; i < 8; i++) l[2*i +: 2] = {1'b0, iv[i]};
      for (int g = 0; g < 4; g++) l[2*(8+g) +: 2] = {1'b0, ov[g]};
      l[2*13 +: 2] = 2'b01;   // supply pin reads high
      return l;
   endfunction

   function automatic logic [3:0] nand4(input logic [7:0] iv);
      logic [3:0] o;
      for (int g = 0; g < 4; g++) o[g] = ~(iv[2*g] & iv[2*g+1]);
      return o;
   endfunction

   task automatic step(); @(posedge clk); #1; endtask

   // present pins, then make one qualifying trigger transition
   task automatic sample(input logic [31:0] l);
      step(); pin_lvl = l; trig_clk = ~trig_rise;
      step(); trig_clk = trig_rise;
      step(); trig_clk = ~trig_rise;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [CW-1:0] c0;
      // roles: pins 0-7 input, 8-11 output, 12 ground, 13 supply, 14-15 ground
      pin_role = '0;
      for (int p = 8; p < 12; p++) pin_role[2*p +: 2] = 2'b01;
      pin_role[2*12 +: 2] = 2'b10; pin_role[2*13 +: 2] = 2'b11;
      pin_role[2*14 +: 2] = 2'b10; pin_role[2*15 +: 2] = 2'b10;
      pin_lvl = lvl_of(8'h00, 4'hF);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R11 reset state
      chk(verdict == 2'd2, "R11 verdict after reset", verdict, 2);
      chk(cov_count == 0 && !ff_valid && !rail_fault, "R11 counters after reset",
          {cov_count, ff_valid, rail_fault}, 0);

      // load NAND table with the window closed
      for (int a = 0; a < DEPTH; a++) begin
         tbl_we = 1; tbl_addr = 8'(a); tbl_data = {4'h0, nand4(8'(a))}; step();
      end
      tbl_we = 0;

      // R9: wrong write with window open must be ignored
      start = 1; step();
      tbl_we = 1; tbl_addr = 8'h00; tbl_data = 8'h00; step(); tbl_we = 0;

      // full sweep, R4 packing and R8 good verdict
      for (int a = 0; a < DEPTH; a++) sample(lvl_of(8'(a), nand4(8'(a))));
      step();
      chk(verdict == 2'd0, "R8/R9 full correct sweep gives all-good", verdict, 0);
      chk(cov_count == 9'd256, "R6 full coverage count", cov_count, 256);
      chk(combo_fail[0] == 1'b0, "R9 entry 0 kept its pre-window value", combo_fail[0], 0);

      // R10 clear
      clr = 1; step(); clr = 0; step();
      chk(cov_count == 0 && !ff_valid && verdict == 2'd2 && combo_seen == '0,
          "R10 clear empties record", cov_count, 0);

      // R4: only pin 0 high -> index 1
      sample(lvl_of(8'h01, nand4(8'h01))); step();
      chk(combo_seen[1] && cov_count == 1, "R4 pin 0 is index bit 0", combo_seen[1], 1);
      // only pin 7 high -> index 0x80
      sample(lvl_of(8'h80, nand4(8'h80))); step();
      chk(combo_seen[8'h80] && cov_count == 2, "R4 pin 7 is index bit 7", combo_seen[8'h80], 1);

      // R1: pin change with no trigger transition
      c0 = cov_count;
      step(); pin_lvl = lvl_of(8'h03, nand4(8'h03)); repeat (4) step();
      chk(cov_count == c0 && !combo_seen[3], "R1 no edge means no sample", cov_count, c0);
      // R1: wrong polarity (1 -> 0) in rising mode
      stop = 1; step(); trig_clk = 1; step(); step(); stop = 0;
      pin_lvl = lvl_of(8'h05, nand4(8'h05)); step();
      trig_clk = 0; step(); step();
      chk(!combo_seen[5], "R1 falling change ignored in rising mode", combo_seen[5], 0);
      // R1: falling mode accepts 1 -> 0
      stop = 1; trig_rise = 0; step(); trig_clk = 1; step(); step(); stop = 0;
      sample(lvl_of(8'h06, nand4(8'h06))); step();
      chk(combo_seen[6] == 1'b1, "R1 falling mode samples on 1 to 0", combo_seen[6], 1);
      stop = 1; trig_rise = 1; step(); trig_clk = 0; step(); step(); stop = 0;

      // R3: window closed by stop, then by start low
      c0 = cov_count;
      stop = 1; sample(lvl_of(8'h09, nand4(8'h09)));
      stop = 0; start = 0; sample(lvl_of(8'h0A, nand4(8'h0A))); step();
      chk(cov_count == c0 && !combo_seen[9] && !combo_seen[10], "R3 closed window records nothing",
          cov_count, c0);
      start = 1;

      // R2: settle filter with settle_n = 2
      settle_n = 4'd2; c0 = cov_count;
      sample(lvl_of(8'h11, nand4(8'h11))); step();
      chk(!combo_seen[8'h11], "R2 first sample of new value rejected", combo_seen[8'h11], 0);
      sample(lvl_of(8'h11, nand4(8'h11))); step();
      chk(!combo_seen[8'h11], "R2 second identical sample rejected", combo_seen[8'h11], 0);
      sample(lvl_of(8'h11, nand4(8'h11))); step();
      chk(combo_seen[8'h11] && cov_count == c0 + 1, "R2 third identical sample accepted",
          combo_seen[8'h11], 1);
      settle_n = 4'd0;

      // R7: wrong output, then a second fault that must not overwrite
      sample(lvl_of(8'h0F, 4'b0011)); step();
      chk(ff_valid && ff_in == 8'h0F && ff_obs == 8'h03 && ff_exp == 8'h0C,
          "R7 first mismatch latched", {ff_in, ff_obs, ff_exp}, 24'h0F030C);
      chk(verdict == 2'd1, "R8 failure verdict", verdict, 1);
      begin
         logic [31:0] l;
         l = lvl_of(8'h22, nand4(8'h22)); l[2*9 +: 2] = 2'b10;  // invalid output level
         sample(l); step();
      end
      chk(ff_in == 8'h0F && combo_fail[8'h22], "R7 invalid output fails, record held",
          ff_in, 8'h0F);

      // R5: ground pin reads high
      clr = 1; step(); clr = 0;
      begin
         logic [31:0] l;
         l = lvl_of(8'h01, nand4(8'h01)); l[2*12 +: 2] = 2'b01;
         sample(l); step();
      end
      chk(rail_fault && verdict == 2'd1, "R5 ground pin high flags rail fault", rail_fault, 1);
      sample(lvl_of(8'h02, nand4(8'h02))); step();
      chk(rail_fault == 1'b1, "R5 rail fault stays set", rail_fault, 1);

      // R8: invalid input gives not-testable verdict
      clr = 1; step(); clr = 0;
      sample(lvl_of(8'h02, nand4(8'h02)));
      begin
         logic [31:0] l;
         l = lvl_of(8'h00, nand4(8'h00)); l[2*3 +: 2] = 2'b11;
         sample(l); step();
      end
      chk(verdict == 2'd3 && cov_count == 1, "R8 invalid input gives not-testable", verdict, 3);

      repeat (3) step();
      finish_run();
   end
endmodule